// File: doc/BRIEF.md
# UART Transmit Byte Queue with Fill Threshold

This block sits between a register write port and a UART serializer. Software pushes characters one at a time by writing a data register. The serializer takes the oldest byte from the head of the queue and reports each finished character with a one-cycle strobe, which removes that byte. The queue keeps a fill count and derives full and empty status from it. It offers a synchronous software flush and a read-back of the fill count.

Two event outputs go to an interrupt controller outside this block. The watermark output is a level flag. It rises when a push leaves the fill count at or above a programmable 2-bit threshold, and it falls when a pop leaves the count below that threshold. The drain output is a one-cycle pulse, raised when a pop empties the queue. Status, control and count are read through a combinational read port.

Top module: `uart_txq`

## Requirements
- R1: After reset the fill count is 0, the status word (read address 0x14) reads 0x3C, the control word (0x20) reads 0, `wm_o` and `empty_evt_o` are low and `tx_avail_o` is low.
- R2: A write strobe to address 0x1C stores bits 7:0 of the write data at the tail. Bytes appear on `tx_byte_o` in the order they were written.
- R3: A `tx_done_i` strobe while `tx_en_i` is high and the queue is not empty removes the head byte. While `tx_en_i` is low, `tx_done_i` has no effect on the count or on the head byte.
- R4: A push and a pop accepted in the same cycle leave the fill count unchanged and advance the head.
- R5: Status bit 0 (full) is 1 exactly when the count equals the capacity of 32. A data write while full is dropped: the count and the stored bytes do not change.
- R6: Status bit 2 (empty) is 1 exactly when the count is 0, and any accepted push clears it. Status bits 5:3 always read as 1 and bit 1 always reads as 0.
- R7: Bits 4:0 of the word at 0x24 show the fill count modulo 32, so a full queue reads 0 there. All other bits read as 0.
- R8: The threshold is bits 6:5 of a write to 0x20, taken as an unsigned value from 0 to 3. A push-only cycle that leaves count >= threshold sets `wm_o`. A pop-only cycle that leaves count < threshold clears it. In every other cycle `wm_o` holds its value.
- R9: `empty_evt_o` is high for exactly the one cycle after a pop-only cycle that leaves the count at 0.
- R10: A write to 0x20 with bit 1 set empties the queue on that edge: the count goes to 0, empty is set and `wm_o` is cleared. No drain pulse is produced, and a pop in the same cycle is ignored.
- R11: Reading 0x20 returns the stored threshold in bits 6:5. Bit 1 (the flush bit) and every other bit read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 6 | Register read byte address |
| rd_data_o | output | 32 | Register read data (combinational) |
| tx_en_i | input | 1 | Transmitter enable; gates pops |
| tx_done_i | input | 1 | Serializer finished one character |
| tx_byte_o | output | 8 | Byte at the head of the queue |
| tx_avail_o | output | 1 | Queue holds at least one byte |
| wm_o | output | 1 | Fill threshold flag |
| empty_evt_o | output | 1 | One-cycle pulse when a pop drains the queue |

## Verification
A wrong pointer shows up as the wrong byte on `tx_byte_o` at the next pop. A full queue is the hardest case, because the modulo-32 count field reads 0 there while the status word must still report full. A miscounted fill level appears in the 0x24 field and in the status bits on the cycle after the edge that caused it. It also appears in `wm_o` at the first push or pop that crosses the threshold, so each table step checks the count, the flag and the drain pulse together. A flush that misses a register is exposed at the next read or push: the count, the flag and the order of later bytes all have to match a freshly reset queue.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    // Register byte offsets; software depends on them
    localparam logic [7:0] OFF_STATUS = 8'h14;
    localparam logic [7:0] OFF_WDATA  = 8'h1C;
    localparam logic [7:0] OFF_QCTRL  = 8'h20;
    localparam logic [7:0] OFF_QLEVEL = 8'h24;

    // Bit positions inside the control word
    localparam int FLUSH_BIT = 1;
    localparam int THR_LSB   = 5;
    localparam int THR_W     = 2;

    // Bit positions inside the status word
    localparam int ST_FULL_BIT  = 0;
    localparam int ST_EMPTY_BIT = 2;

    typedef logic [THR_W-1:0] thr_t;

    // Decoded write command handed from the register slice to the core
    typedef struct packed {
        logic       push;
        logic [7:0] byte_val;
        logic       flush;
    } wcmd_t;

endpackage

// File: rtl/uart_txq_csr.sv
module uart_txq_csr
    import uart_txq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 6,
    parameter int FLD_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [CNT_W-1:0]  level_i,
    input  logic              full_i,
    input  logic              empty_i,
    output wcmd_t             cmd_o,
    output thr_t              thr_o,
    output logic [31:0]       rd_data_o
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_WDATA  = ADDR_W'(OFF_WDATA);
    localparam logic [ADDR_W-1:0] A_QCTRL  = ADDR_W'(OFF_QCTRL);
    localparam logic [ADDR_W-1:0] A_QLEVEL = ADDR_W'(OFF_QLEVEL);

    typedef struct packed {
        thr_t thr;
    } csr_state_t;

    csr_state_t st_d, st_q;
    logic       ctrl_wr;
    logic       unused_wbits;

    assign ctrl_wr      = wr_en_i && (wr_addr_i == A_QCTRL);
    assign unused_wbits = ^{wr_data_i[31:THR_LSB+THR_W], wr_data_i[THR_LSB-1:FLUSH_BIT+1],
                            wr_data_i[0]};

    always_comb begin
        st_d           = st_q;
        cmd_o.push     = wr_en_i && (wr_addr_i == A_WDATA);
        cmd_o.byte_val = wr_data_i[7:0];
        cmd_o.flush    = ctrl_wr && wr_data_i[FLUSH_BIT];
        if (ctrl_wr) begin
            st_d.thr = wr_data_i[THR_LSB +: THR_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_o = st_q.thr;

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_STATUS: begin
                rd_data_o[5:3]          = 3'b111;
                rd_data_o[ST_EMPTY_BIT] = empty_i;
                rd_data_o[ST_FULL_BIT]  = full_i;
            end
            A_QCTRL: begin
                rd_data_o[THR_LSB +: THR_W] = st_q.thr;
            end
            A_QLEVEL: begin
                rd_data_o[FLD_W-1:0] = level_i[FLD_W-1:0];
            end
            default: rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/uart_txq_ctl.sv
module uart_txq_ctl
    import uart_txq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_req_i,
    input  logic             pop_req_i,
    input  logic             flush_i,
    input  thr_t             thr_i,
    output logic             push_ok_o,
    output logic             pop_ok_o,
    output logic [CNT_W-1:0] level_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             wm_o,
    output logic             evt_o
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] level;
        logic             wm;
        logic             evt;
    } ctl_state_t;

    ctl_state_t       st_d, st_q;
    logic [CNT_W-1:0] thr_ext;
    logic [CNT_W-1:0] next_lvl;

    assign full_o    = (st_q.level == CAP);
    assign empty_o   = (st_q.level == '0);
    assign push_ok_o = push_req_i && !full_o && !flush_i;
    assign pop_ok_o  = pop_req_i && !empty_o && !flush_i;
    assign thr_ext   = CNT_W'(thr_i);

    always_comb begin
        next_lvl = st_q.level;
        if (push_ok_o && !pop_ok_o) begin
            next_lvl = st_q.level + 1'b1;
        end else if (pop_ok_o && !push_ok_o) begin
            next_lvl = st_q.level - 1'b1;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (flush_i) begin
            st_d.level = '0;
            st_d.wm    = 1'b0;
        end else begin
            st_d.level = next_lvl;
            if (push_ok_o && !pop_ok_o && (next_lvl >= thr_ext)) begin
                st_d.wm = 1'b1;
            end
            if (pop_ok_o && !push_ok_o) begin
                if (next_lvl < thr_ext) begin
                    st_d.wm = 1'b0;
                end
                st_d.evt = (next_lvl == '0);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign wm_o    = st_q.wm;
    assign evt_o   = st_q.evt;

endmodule

// File: rtl/uart_txq_mem.sv
module uart_txq_mem #(
    parameter int DEPTH = 32,
    parameter int PTR_W = 5
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       push_ok_i,
    input  logic       pop_ok_i,
    input  logic       flush_i,
    input  logic [7:0] byte_i,
    output logic [7:0] head_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
    } ptr_t;

    ptr_t       ptr_d, ptr_q;
    logic [7:0] store [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (flush_i) begin
            ptr_d = '0;
        end else begin
            if (push_ok_i) begin
                ptr_d.wp = ptr_q.wp + 1'b1;
            end
            if (pop_ok_i) begin
                ptr_d.rp = ptr_q.rp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_ok_i && !flush_i) begin
            store[ptr_q.wp] <= byte_i;
        end
    end

    assign head_o = store[ptr_q.rp];

endmodule

// File: rtl/uart_txq.sv
module uart_txq
    import uart_txq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    input  logic              tx_en_i,
    input  logic              tx_done_i,
    output logic [7:0]        tx_byte_o,
    output logic              tx_avail_o,
    output logic              wm_o,
    output logic              empty_evt_o
);

    // DEPTH must be a power of two so the pointers wrap on their own
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam int FLD_W = PTR_W;

    wcmd_t            cmd;
    thr_t             thr;
    logic [CNT_W-1:0] level;
    logic             full;
    logic             empty;
    logic             push_ok;
    logic             pop_ok;
    logic             pop_req;

    assign pop_req = tx_done_i && tx_en_i;

    uart_txq_csr #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .FLD_W  (FLD_W)
    ) csr_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .level_i   (level),
        .full_i    (full),
        .empty_i   (empty),
        .cmd_o     (cmd),
        .thr_o     (thr),
        .rd_data_o (rd_data_o)
    );

    uart_txq_ctl #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) ctl_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .push_req_i (cmd.push),
        .pop_req_i  (pop_req),
        .flush_i    (cmd.flush),
        .thr_i      (thr),
        .push_ok_o  (push_ok),
        .pop_ok_o   (pop_ok),
        .level_o    (level),
        .full_o     (full),
        .empty_o    (empty),
        .wm_o       (wm_o),
        .evt_o      (empty_evt_o)
    );

    uart_txq_mem #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) mem_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_ok_i (push_ok),
        .pop_ok_i  (pop_ok),
        .flush_i   (cmd.flush),
        .byte_i    (cmd.byte_val),
        .head_o    (tx_byte_o)
    );

    assign tx_avail_o = !empty;

endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] level,
    input logic             push_req,
    input logic             pop_req,
    input logic             flush,
    input logic             wm,
    input logic             evt,
    input logic             full,
    input logic             empty
);

    always_comb begin
        if (rst_ni) begin
            AST_NO_OVERFLOW: assert (level <= CNT_W'(DEPTH)); // R5
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full && push_req && !pop_req && !flush |=> $stable(level)); // R5

    AST_TXEN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pop_req && !push_req && !flush |=> $stable(level)); // R3

    AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_req && !pop_req && !flush |=> !empty); // R6

    AST_DRAIN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt |=> !evt); // R9

    AST_DRAIN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt |-> empty && $past(pop_req) && !$past(push_req) && ($past(level) == 1)); // R9

    AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush |=> empty && !wm && !evt); // R10

endmodule

bind uart_txq uart_txq_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level    (level),
    .push_req (cmd.push),
    .pop_req  (pop_req),
    .flush    (cmd.flush),
    .wm       (wm_o),
    .evt      (empty_evt_o),
    .full     (full),
    .empty    (empty)
);

// File: tb/uart_txq_tb_top.sv
module uart_txq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tx_en = 1'b1;
    logic        tx_done = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        wm;
    logic        evt;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    uart_txq dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .tx_en_i     (tx_en),
        .tx_done_i   (tx_done),
        .tx_byte_o   (tx_byte),
        .tx_avail_o  (tx_avail),
        .wm_o        (wm),
        .empty_evt_o (evt)
    );

    typedef struct packed {
        logic [1:0] op;   // 0 idle, 1 push, 2 pop, 3 threshold write
        logic [7:0] dat;
        logic [5:0] lvl;
        logic       wm;
        logic       evt;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 8'd2,   6'd0, 1'b0, 1'b0},
        '{2'd1, 8'hA1, 6'd1, 1'b0, 1'b0},
        '{2'd1, 8'hB2, 6'd2, 1'b1, 1'b0},
        '{2'd1, 8'hC3, 6'd3, 1'b1, 1'b0},
        '{2'd2, 8'h00, 6'd2, 1'b1, 1'b0},
        '{2'd2, 8'h00, 6'd1, 1'b0, 1'b0},
        '{2'd2, 8'h00, 6'd0, 1'b0, 1'b1},
        '{2'd0, 8'h00, 6'd0, 1'b0, 1'b0},
        '{2'd3, 8'd0,   6'd0, 1'b0, 1'b0},
        '{2'd1, 8'h11, 6'd1, 1'b1, 1'b0},
        '{2'd2, 8'h00, 6'd0, 1'b1, 1'b1},
        '{2'd3, 8'd3,   6'd0, 1'b1, 1'b0},
        '{2'd1, 8'h22, 6'd1, 1'b1, 1'b0},
        '{2'd2, 8'h00, 6'd0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // One cycle of stimulus, applied at a falling edge and removed at the next one
    task automatic step(input logic we, input logic [5:0] a, input logic [31:0] d,
                        input logic done);
        @(negedge clk);
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        tx_done = done;
        @(negedge clk);
        wr_en   = 1'b0;
        tx_done = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        step(1'b1, 6'h1C, {24'h0, b}, 1'b0);
    endtask

    task automatic pop();
        step(1'b0, 6'h00, 32'h0, 1'b1);
    endtask

    task automatic cfg(input logic [1:0] thr, input logic fl);
        step(1'b1, 6'h20, (32'(thr) << 5) | (32'(fl) << 1), 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(6'h14, v); chk("R1 status", v, 32'h3C);
        rd(6'h24, v); chk("R1 level", v, 32'h0);
        rd(6'h20, v); chk("R1 ctrl", v, 32'h0);
        chk("R1 wm/evt/avail", {29'h0, wm, evt, tx_avail}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(6'h14, v); chk("R1 status after release", v, 32'h3C);

        // Table: R8 watermark and R9 drain pulse across thresholds
        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].op)
                2'd0: step(1'b0, 6'h00, 32'h0, 1'b0);
                2'd1: push(VEC[i].dat);
                2'd2: pop();
                default: cfg(VEC[i].dat[1:0], 1'b0);
            endcase
            rd(6'h24, v);
            chk($sformatf("R7 table row %0d level", i), v, 32'(VEC[i].lvl));
            chk($sformatf("R8 table row %0d wm", i), 32'(wm), 32'(VEC[i].wm));
            chk($sformatf("R9 table row %0d evt", i), 32'(evt), 32'(VEC[i].evt));
        end

        // R11: control readback, flush bit reads as zero
        cfg(2'd1, 1'b0);
        rd(6'h20, v); chk("R11 ctrl readback", v, 32'h20);

        // R2 and R6: order and empty clearing
        push(8'h5A);
        rd(6'h14, v); chk("R6 empty cleared by push", v, 32'h38);
        push(8'h6B);
        chk("R2 head first", 32'(tx_byte), 32'h5A);
        pop();
        chk("R2 head second", 32'(tx_byte), 32'h6B);

        // R3: done strobe ignored while transmitter disabled
        tx_en = 1'b0;
        pop();
        rd(6'h24, v); chk("R3 gated level", v, 32'h1);
        chk("R3 gated head", 32'(tx_byte), 32'h6B);
        tx_en = 1'b1;

        // R4: push and pop together
        step(1'b1, 6'h1C, 32'h7C, 1'b1);
        rd(6'h24, v); chk("R4 level unchanged", v, 32'h1);
        chk("R4 head advanced", 32'(tx_byte), 32'h7C);
        pop();
        chk("R9 drain pulse", 32'(evt), 32'h1);

        // R5 and R7: fill to capacity, overflow write dropped
        for (int i = 0; i < 32; i++) push(8'(8'h80 + i));
        rd(6'h14, v); chk("R5 full status", v, 32'h39);
        rd(6'h24, v); chk("R7 full level field", v, 32'h0);
        push(8'hEE);
        rd(6'h14, v); chk("R5 still full after drop", v, 32'h39);
        for (int i = 0; i < 32; i++) begin
            chk($sformatf("R5 drain byte %0d", i), 32'(tx_byte), 32'(8'h80 + i));
            pop();
        end
        rd(6'h14, v); chk("R5 empty after 32 pops", v, 32'h3C);

        // R10: flush with pop in the same cycle
        push(8'h01); push(8'h02); push(8'h03);
        chk("R8 wm before flush", 32'(wm), 32'h1);
        step(1'b1, 6'h20, 32'h42, 1'b1);
        rd(6'h24, v); chk("R10 level zero", v, 32'h0);
        rd(6'h14, v); chk("R10 status empty", v, 32'h3C);
        chk("R10 wm/evt low", {30'h0, wm, evt}, 32'h0);
        rd(6'h20, v); chk("R11 thr kept, flush reads 0", v, 32'h40);
        push(8'h44);
        chk("R10 fresh head", 32'(tx_byte), 32'h44);

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule